// File: doc/BRIEF.md
# Serial Bootstrap Download Controller

This controller loads a program image from a serial link into on-chip RAM during bootstrap start-up. A serial receiver hands it bytes with a one-cycle valid strobe. The controller stores each byte at the next RAM location. The first byte goes to address 0, and the address steps up by one for every byte accepted. The RAM holds 512 bytes, so the largest image is 512 bytes.

A download stops in one of two ways. The first is a silence on the line lasting four character times after the most recent byte. The second is the arrival of the byte for the top RAM address. When either happens, the controller emits a single-cycle start strobe carrying the jump address 0x0000. It then stays inert until reset and ignores every later byte. Time is measured with a baud-period tick input, and one character is ten ticks.

The controller also converts the serial transmit bit into an open-drain pull-down enable, which makes the transmit line wired-OR. An external pull-up supplies the high level.

Top module: `boot_loader_ctrl`

## Requirements
- R1: After reset, `ram_we` and `go_pulse` are 0 and `ram_addr` is 0.
- R2: While loading, a cycle with `rx_valid` high drives `ram_we` high in that same cycle, with `ram_wdata` equal to `rx_data` and `ram_addr` equal to the count of bytes accepted before it. The first byte lands at 0. The address rises by one per byte and never passes 511.
- R3: Before the first byte arrives, any number of baud ticks causes no start strobe.
- R4: Once one byte has arrived, the 40th tick with no byte in between ends the download. `go_pulse` goes high in the cycle after the cycle that carries that 40th tick.
- R5: Each accepted byte restarts the idle count. A byte that arrives in the same cycle as the tick that would be the 40th is stored, and no start strobe follows from that tick.
- R6: Writing the byte for address 511 ends the download. `go_pulse` goes high in the next cycle, with no ticks needed.
- R7: `go_pulse` is high for exactly one cycle, and `go_addr` reads 0x0000 in that cycle.
- R8: After the download ends, further `rx_valid` strobes leave `ram_we` low and raise no further start strobe, until reset.
- R9: `tx_pull_low` is 1 exactly when `tx_bit` is 0, at any time, including during reset.

Note: `tx_bit` is driven by the serial transmitter (1 = idle/mark). `tx_pull_low` drives the gate of an open-drain pull-down on the transmit pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_bit | input | 1 | Serial transmit bit from the transmitter (1 = idle/mark) |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 9 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| go_pulse | output | 1 | Single-cycle start strobe |
| go_addr | output | 16 | Jump address, 0x0000 |
| tx_pull_low | output | 1 | Open-drain pull-down enable for the transmit pin |

## Verification
The case that matters most is a byte arriving in the same cycle as the tick that would complete the 40-tick silence. In that cycle, storing the byte and ending the download both want to happen.

The bench provokes this case by sending 39 idle ticks after a byte, then presenting the next byte together with the 40th tick. It judges the outcome in two ways:
- A scoreboard must see the byte written at its expected address.
- The reference model, which restarts its own tick count on every write, must expect no start strobe there.

The bench then confirms that the strobe appears only 40 ticks after that late byte.

// File: rtl/boot_pkg.sv
// Package boot_pkg
// Shared types for the bootstrap download controller.
// Assumes: nothing beyond a synthesizable SystemVerilog flow.
package boot_pkg;

    // Sequencer phases: loading bytes, issuing the start strobe, inert.
    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_HANDOFF = 2'd1,
        ST_DONE    = 2'd2
    } boot_state_t;

endpackage

// File: rtl/boot_wr_ptr.sv
// Module boot_wr_ptr
// Sequential RAM write pointer. Starts at 0, steps by one per write
// and saturates at DEPTH-1.
// Assumes: wr_en is high for exactly one cycle per stored byte.
module boot_wr_ptr #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    output logic [AW-1:0] addr,
    output logic          at_top
);

    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    assign at_top = (addr == TOP);

    // Advance the pointer on each write, holding at the top location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (wr_en && !at_top) begin
            addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/boot_idle_timer.sv
// Module boot_idle_timer
// Counts baud ticks since the most recent byte. Flags expiry on the
// LIMIT-th tick. The timer is inactive until the first byte arms it.
// Assumes: restart wins over a tick in the same cycle.
module boot_idle_timer #(
    parameter int LIMIT = 40,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    input  logic tick,
    output logic expire
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;
    logic          armed;

    // Expiry on the tick that completes the idle window, unless a byte lands.
    assign expire = enable && armed && tick && !restart && (cnt == LAST);

    // Track arming and the tick count since the latest byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (restart) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (enable && armed && tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/boot_seq_fsm.sv
// Module boot_seq_fsm
// Phase sequencer: loads until the last byte or an idle expiry, then
// issues one start strobe and stays inert until reset.
// Assumes: byte_in is only asserted while loading is high.
module boot_seq_fsm
    import boot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_in,
    input  logic last_byte,
    input  logic expire,
    output logic loading,
    output logic go
);

    boot_state_t state, state_nx;

    assign loading = (state == ST_LOAD);
    assign go      = (state == ST_HANDOFF);

    // Next-phase selection; a final byte and an expiry both end loading.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD: begin
                if (byte_in && last_byte) begin
                    state_nx = ST_HANDOFF;
                end else if (expire) begin
                    state_nx = ST_HANDOFF;
                end
            end
            ST_HANDOFF: state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_DONE;
            default:    state_nx = ST_DONE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOAD;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/boot_od_tx.sv
// Module boot_od_tx
// Open-drain transmit stage. Asserts the pull-down enable when the
// serial bit is low and releases the line when it is high.
// Assumes: an external pull-up provides the high level.
module boot_od_tx (
    input  logic tx_bit,
    output logic pull_low
);

    // Low bit means pull the line down; high bit means float.
    assign pull_low = ~tx_bit;

endmodule

// File: rtl/boot_loader_ctrl.sv
// Module boot_loader_ctrl
// Bootstrap download controller. Writes serial bytes into RAM from
// address 0. Ends on a four-character idle gap or on the top RAM
// location, then strobes the start address once.
// Assumes: rx_valid is a one-cycle strobe per byte, and baud_tick is a
// one-cycle strobe per bit period.
module boot_loader_ctrl #(
    parameter int              RAM_DEPTH  = 512,
    parameter int              CHAR_TICKS = 10,
    parameter int              IDLE_CHARS = 4,
    parameter int              PC_W       = 16,
    parameter logic [PC_W-1:0] JUMP_ADDR  = '0,
    localparam int             AW         = $clog2(RAM_DEPTH),
    localparam int             IDLE_LIMIT = CHAR_TICKS * IDLE_CHARS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            baud_tick,
    input  logic            rx_valid,
    input  logic [7:0]      rx_data,
    input  logic            tx_bit,
    output logic            ram_we,
    output logic [AW-1:0]   ram_addr,
    output logic [7:0]      ram_wdata,
    output logic            go_pulse,
    output logic [PC_W-1:0] go_addr,
    output logic            tx_pull_low
);

    logic loading;
    logic at_top;
    logic expire;

    // Byte acceptance only while loading.
    assign ram_we    = rx_valid && loading;
    assign ram_wdata = rx_data;
    assign go_addr   = JUMP_ADDR;

    boot_wr_ptr #(.DEPTH(RAM_DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ram_we),
        .addr   (ram_addr),
        .at_top (at_top)
    );

    boot_idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (loading),
        .restart (ram_we),
        .tick    (baud_tick),
        .expire  (expire)
    );

    boot_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_in   (ram_we),
        .last_byte (at_top),
        .expire    (expire),
        .loading   (loading),
        .go        (go_pulse)
    );

    boot_od_tx u_tx (
        .tx_bit   (tx_bit),
        .pull_low (tx_pull_low)
    );

endmodule

// File: rtl/boot_loader_chk.sv
// Module boot_loader_chk
// Assertion checker for boot_loader_ctrl, attached by bind. Keeps its
// own idle-tick count and done flag, independent of the design.
module boot_loader_chk #(
    parameter int RAM_DEPTH = 512,
    parameter int IDLE_LIMIT = 40,
    parameter int PC_W = 16,
    localparam int AW = $clog2(RAM_DEPTH),
    localparam int CW = $clog2(IDLE_LIMIT + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            baud_tick,
    input logic            ram_we,
    input logic [AW-1:0]   ram_addr,
    input logic            go_pulse,
    input logic [PC_W-1:0] go_addr
);

    localparam logic [AW-1:0] TOP  = AW'(RAM_DEPTH - 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_LIMIT - 1);

    logic [CW-1:0] idle_cnt;
    logic          seen_byte;
    logic          done_q;

    // Checker-side model of idle ticks, arming and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt  <= '0;
            seen_byte <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            if (go_pulse) done_q <= 1'b1;
            if (ram_we) begin
                idle_cnt  <= '0;
                seen_byte <= 1'b1;
            end else if (baud_tick && seen_byte && idle_cnt != LAST) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr != TOP) |=> (ram_addr == $past(ram_addr) + 1'b1));

    assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr == TOP) |=> (ram_addr == TOP));

    assert_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_byte |-> !go_pulse);

    assert_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_byte && baud_tick && !ram_we && !done_q && !go_pulse
         && idle_cnt == LAST) |=> go_pulse);

    assert_last_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr == TOP) |=> go_pulse);

    assert_single_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |=> !go_pulse);

    assert_go_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |-> (go_addr == '0));

    assert_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!ram_we && !go_pulse));

endmodule

bind boot_loader_ctrl boot_loader_chk #(
    .RAM_DEPTH  (RAM_DEPTH),
    .IDLE_LIMIT (IDLE_LIMIT),
    .PC_W       (PC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .go_pulse  (go_pulse),
    .go_addr   (go_addr)
);

// File: tb/boot_loader_ctrl_tb.sv
// Scoreboard bench for boot_loader_ctrl. Inputs change 1 ns after a
// rising edge, and the monitor samples on the falling edge.
module boot_loader_ctrl_tb;

    localparam int DEPTH = 512;
    localparam int IDLE  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_bit = 1'b1;
    logic        ram_we;
    logic [8:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic        go_pulse;
    logic [15:0] go_addr;
    logic        tx_pull_low;

    int checks = 0;
    int fails  = 0;

    // Scoreboard and reference-model state.
    logic [16:0] exp_q[$];
    int  exp_addr  = 0;
    bit  m_armed   = 0;
    bit  m_done    = 0;
    bit  go_due    = 0;
    int  m_ticks   = 0;
    int  go_count  = 0;

    boot_loader_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .tx_bit      (tx_bit),
        .ram_we      (ram_we),
        .ram_addr    (ram_addr),
        .ram_wdata   (ram_wdata),
        .go_pulse    (go_pulse),
        .go_addr     (go_addr),
        .tx_pull_low (tx_pull_low)
    );

    initial forever #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Present one byte for one cycle, optionally together with a tick.
    task automatic send_byte(input logic [7:0] d, input bit with_tick);
        if (!m_done) begin
            exp_q.push_back({exp_addr[8:0], d});
            exp_addr++;
        end
        rx_valid  = 1'b1;
        rx_data   = d;
        baud_tick = with_tick;
        if (m_done) begin
            #1;
            chk(ram_we == 1'b0, "R8 byte ignored after handoff", ram_we, 0);
        end
        step();
        rx_valid  = 1'b0;
        baud_tick = 1'b0;
    endtask

    // n ticks, each separated by a quiet cycle.
    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1'b1;
            step();
            baud_tick = 1'b0;
            step();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_valid = 1'b0;
        baud_tick = 1'b0;
        step();
        step();
        exp_q.delete();
        exp_addr = 0;
        go_count = 0;
        rst_n = 1'b1;
        step();
    endtask

    // Monitor: pops expected writes and predicts the start strobe.
    initial forever begin
        @(negedge clk);
        if (!rst_n) begin
            m_armed = 0; m_done = 0; go_due = 0; m_ticks = 0;
        end else begin
            if (go_pulse || go_due) begin
                chk(go_pulse == go_due, "R4/R6/R7 start strobe timing", go_pulse, go_due);
            end
            if (go_pulse) begin
                go_count++;
                chk(go_addr == 16'h0000, "R7 jump address", go_addr, 0);
            end
            go_due = 0;
            if (ram_we) begin
                if (m_done || exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected write", ram_addr, -1);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    chk({ram_addr, ram_wdata} == e, "R2 write address/data",
                        {ram_addr, ram_wdata}, e);
                    m_armed = 1;
                    m_ticks = 0;
                    if (ram_addr == 9'(DEPTH - 1)) begin
                        go_due = 1; m_done = 1;   // R6
                    end
                end
            end else if (baud_tick && m_armed && !m_done) begin
                m_ticks++;
                if (m_ticks == IDLE) begin
                    go_due = 1; m_done = 1;       // R4
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        // R9 during reset and after.
        tx_bit = 1'b0; #1;
        chk(tx_pull_low == 1'b1, "R9 pull low on zero bit", tx_pull_low, 1);
        do_reset();
        // R1 reset state.
        chk(ram_we == 1'b0 && go_pulse == 1'b0, "R1 outputs idle", {ram_we, go_pulse}, 0);
        chk(ram_addr == 9'd0, "R1 address zero", ram_addr, 0);
        tx_bit = 1'b1; #1;
        chk(tx_pull_low == 1'b0, "R9 release on one bit", tx_pull_low, 0);
        tx_bit = 1'b0; #1;
        chk(tx_pull_low == 1'b1, "R9 pull low again", tx_pull_low, 1);
        tx_bit = 1'b1;
        step();

        // R3: long tick run before any byte.
        idle_ticks(120);
        chk(go_count == 0, "R3 no start before first byte", go_count, 0);

        // R2/R4: short image, gaps below the limit, then silence.
        send_byte(8'hA5, 0);
        idle_ticks(10);
        send_byte(8'h3C, 1);
        idle_ticks(39);
        send_byte(8'h00, 0);
        send_byte(8'hFF, 0);
        idle_ticks(39);
        chk(go_count == 0, "R4 no start at 39 ticks", go_count, 0);
        idle_ticks(1);
        step();
        chk(go_count == 1, "R4 start after 40 ticks", go_count, 1);
        chk(exp_q.size() == 0, "R2 all bytes written", exp_q.size(), 0);
        // R8: later bytes and ticks ignored.
        send_byte(8'h77, 0);
        idle_ticks(50);
        chk(go_count == 1, "R8 no second start", go_count, 1);

        // R5: byte together with the would-be 40th tick.
        do_reset();
        send_byte(8'h11, 0);
        idle_ticks(39);
        send_byte(8'h22, 1);
        step();
        chk(go_count == 0, "R5 byte wins over expiry", go_count, 0);
        idle_ticks(39);
        chk(go_count == 0, "R5 count restarted", go_count, 0);
        idle_ticks(1);
        step();
        chk(go_count == 1, "R5 start after restarted window", go_count, 1);

        // R6: fill the whole RAM back to back.
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            send_byte(8'(i * 7 + 3), 0);
        end
        step();
        chk(go_count == 1, "R6 start after top byte", go_count, 1);
        chk(ram_addr == 9'(DEPTH - 1), "R2 address held at top", ram_addr, DEPTH - 1);
        send_byte(8'h5A, 0);
        step();
        chk(go_count == 1, "R8 inert after fill", go_count, 1);
        chk(exp_q.size() == 0, "R2 fill fully written", exp_q.size(), 0);

        summary();
    end

endmodule